// File: doc/BRIEF.md
# Word-Serial Binary Field Multiplier

This block multiplies two elements of a binary extension field GF(2^m) in polynomial basis and returns C(x) = A(x)·B(x) mod P(x). The datapath is a fixed W bits wide. Longer operands are handled by stepping through them one word at a time. This lets one build serve every field size m from 1 up to W·D, where D is the maximum word count. The field size is given on `m_i` together with the start pulse, and the block derives the word count d = ceil(m/W) from it.

Before a multiply, the host writes three things through small write ports. The bits of A go into a one-bit-wide store. B goes into a word store. The low m bits of the modulus go into another word store, with the x^m term implied. After `start_i`, the controller walks the bits of A from a_(m-1) down to a_0. Each bit takes one outer step. Within that step, a single processing element visits the accumulator words from the top word downward. In each cycle it reads one accumulator word and writes back the word above it. The bit shifted out of each lower word becomes the carry into the word above. The reduction decision for the step is latched from bit m-1 while the top word is read. After the last step, `done_o` pulses and the result can be read one word at a time.

Top module: `gfmul_ws`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0 and `c_data_o` is 0 at every word address.
- R2: When idle after a multiply, reading word j of C returns bits jW+W-1..jW of A(x)·B(x) mod P(x). The modulus word store holds bits m-1..0 of P, with x^m implied. A bit i sits at A address i.
- R3: In the top word (index d-1), every bit at a polynomial position of m or above reads as 0.
- R4: An accepted start is followed by exactly m·(d+1) cycles with `busy_o` high. At the end of these, `busy_o` falls and `done_o` is high for exactly one cycle.
- R5: While idle, a word address of d or above reads as 0.
- R6: A start with `m_i` = 0 or `m_i` > W·D is ignored. `busy_o` stays 0, no `done_o` follows, and the previous result remains readable.
- R7: A start asserted while `busy_o` is high has no effect on the running product or its timing.
- R8: The accumulator starts from zero on every multiply. A result does not depend on an earlier product, including one computed with a larger m.
- R9: With m=4, P(x)=x^4+x+1, A(x)=x^3+x^2+x+1 and B(x)=x^3+x^2+x, the result word 0 is 4'b0101.
- R10: With A=0, the result is 0 for any B and P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a multiply when idle |
| m_i | input | $clog2(W·D+1) | Field size sampled with start |
| a_we_i | input | 1 | Write enable, A bit store |
| a_addr_i | input | $clog2(W·D) | Bit index of A |
| a_bit_i | input | 1 | A bit value |
| b_we_i | input | 1 | Write enable, B word store |
| b_addr_i | input | $clog2(D) | B word index |
| b_data_i | input | W | B word |
| p_we_i | input | 1 | Write enable, modulus word store |
| p_addr_i | input | $clog2(D) | Modulus word index |
| p_data_i | input | W | Modulus word, low m bits of P |
| c_addr_i | input | $clog2(D) | Result word read address |
| c_data_o | output | W | Result word, zero while busy or beyond d |
| busy_o | output | 1 | Multiply in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a reduction that depends on the carry chain. This happens when bit m-1 sits in a partly used top word, and at the same time the word-boundary carries shift bits into that word that must be masked off. The bench covers it by drawing random field sizes across all word counts, not only multiples of W. It also runs m=1, m=W, m=2W and m=W·D. A large-m product is followed directly by a small-m one, so stale upper words and old accumulator contents would show up in the read-back. A start pulse is also injected in the middle of a run.

// File: rtl/gfm_pkg.sv
package gfm_pkg;
  typedef enum logic [0:0] {ST_IDLE, ST_RUN} gfm_st_e;
endpackage

// File: rtl/gfm_rf.sv
module gfm_rf #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  parameter int AWD   = 2
) (
  input  logic           clk_i,
  input  logic           we_i,
  input  logic [AWD-1:0] waddr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [AWD-1:0] raddr_i,
  output logic [DW-1:0]  rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/gfm_ctrl.sv
module gfm_ctrl
  import gfm_pkg::*;
#(
  parameter int W = 8,
  parameter int D = 4,
  localparam int MMAX = W * D,
  localparam int MW   = $clog2(MMAX + 1),
  localparam int AW   = (D > 1) ? $clog2(D) : 1,
  localparam int KW   = $clog2(D + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [MW-1:0] m_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [MW-1:0] m_o,
  output logic [KW-1:0] d_o,
  output logic [MW-1:0] bit_o,
  output logic [AW-1:0] rd_addr_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          wr_en_o,
  output logic          cap_o,
  output logic          tail_o,
  output logic          first_o
);
  gfm_st_e       st_q;
  logic [MW-1:0] m_q, bit_q;
  logic [KW-1:0] d_q, k_q;
  logic          done_q;
  logic          accept;

  assign accept = (st_q == ST_IDLE) && start_i && (m_i != '0) && (int'(m_i) <= MMAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      m_q    <= '0;
      d_q    <= '0;
      bit_q  <= '0;
      k_q    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        st_q  <= ST_RUN;
        m_q   <= m_i;
        d_q   <= KW'((int'(m_i) + W - 1) / W);
        bit_q <= m_i - 1'b1;
        k_q   <= '0;
      end else if (st_q == ST_RUN) begin
        if (k_q == d_q) begin
          k_q <= '0;
          if (bit_q == '0) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q - 1'b1;
          end
        end else begin
          k_q <= k_q + 1'b1;
        end
      end
    end
  end

  assign busy_o    = (st_q == ST_RUN);
  assign done_o    = done_q;
  assign m_o       = m_q;
  assign d_o       = d_q;
  assign bit_o     = bit_q;
  // read runs one word below the write: word j is finished once j-1 supplies its carry
  assign rd_addr_o = AW'(int'(d_q) - 1 - int'(k_q));
  assign wr_addr_o = AW'(int'(d_q) - int'(k_q));
  assign wr_en_o   = busy_o && (k_q != '0);
  assign cap_o     = busy_o && (k_q == '0);
  assign tail_o    = busy_o && (k_q == d_q);
  assign first_o   = (bit_q == m_q - 1'b1);
endmodule

// File: rtl/gfm_pe.sv
module gfm_pe #(
  parameter int W = 8,
  parameter int D = 4,
  localparam int MMAX = W * D,
  localparam int MW   = $clog2(MMAX + 1),
  localparam int AW   = (D > 1) ? $clog2(D) : 1,
  localparam int KW   = $clog2(D + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          cap_i,
  input  logic          first_i,
  input  logic          tail_i,
  input  logic [MW-1:0] m_i,
  input  logic [KW-1:0] d_i,
  input  logic [AW-1:0] wr_idx_i,
  input  logic          a_bit_i,
  input  logic [W-1:0]  c_rd_i,
  input  logic [W-1:0]  b_word_i,
  input  logic [W-1:0]  p_word_i,
  output logic [W-1:0]  wr_data_o
);
  logic [W-1:0] hold_q, c_eff, sh, mask;
  logic         msb_q, msb_d;

  always_comb begin
    // first step starts from a zero accumulator; tail cycle has no lower word
    c_eff = (first_i || tail_i) ? '0 : c_rd_i;
    msb_d = 1'b0;
    for (int b = 0; b < W; b++) begin
      if (int'(m_i) - 1 - (int'(d_i) - 1) * W == b) msb_d = c_eff[b];
    end
    sh[0] = c_eff[W-1];
    for (int b = 1; b < W; b++) sh[b] = hold_q[b-1];
    for (int b = 0; b < W; b++) mask[b] = (int'(wr_idx_i) * W + b < int'(m_i));
    wr_data_o = (sh ^ (msb_q ? p_word_i : '0) ^ (a_bit_i ? b_word_i : '0)) & mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      msb_q  <= 1'b0;
    end else if (en_i) begin
      hold_q <= c_eff;
      if (cap_i) msb_q <= msb_d;
    end
  end
endmodule

// File: rtl/gfmul_ws.sv
module gfmul_ws #(
  parameter int W = 8,
  parameter int D = 4,
  localparam int MMAX = W * D,
  localparam int MW   = $clog2(MMAX + 1),
  localparam int AW   = (D > 1) ? $clog2(D) : 1,
  localparam int BW   = (MMAX > 1) ? $clog2(MMAX) : 1,
  localparam int KW   = $clog2(D + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [MW-1:0] m_i,
  input  logic          a_we_i,
  input  logic [BW-1:0] a_addr_i,
  input  logic          a_bit_i,
  input  logic          b_we_i,
  input  logic [AW-1:0] b_addr_i,
  input  logic [W-1:0]  b_data_i,
  input  logic          p_we_i,
  input  logic [AW-1:0] p_addr_i,
  input  logic [W-1:0]  p_data_i,
  input  logic [AW-1:0] c_addr_i,
  output logic [W-1:0]  c_data_o,
  output logic          busy_o,
  output logic          done_o
);
  logic [MW-1:0] m_cur, bit_idx;
  logic [KW-1:0] d_cur;
  logic [AW-1:0] rd_addr, wr_addr, c_raddr;
  logic          wr_en, cap, tail, first, a_cur;
  logic [W-1:0]  c_rd, b_word, p_word, wr_data;

  gfm_ctrl #(.W(W), .D(D)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .m_i,
    .busy_o, .done_o,
    .m_o(m_cur), .d_o(d_cur), .bit_o(bit_idx),
    .rd_addr_o(rd_addr), .wr_addr_o(wr_addr), .wr_en_o(wr_en),
    .cap_o(cap), .tail_o(tail), .first_o(first)
  );

  gfm_rf #(.DW(1), .DEPTH(MMAX), .AWD(BW)) u_amem (
    .clk_i, .we_i(a_we_i), .waddr_i(a_addr_i), .wdata_i(a_bit_i),
    .raddr_i(BW'(bit_idx)), .rdata_o(a_cur)
  );

  gfm_rf #(.DW(W), .DEPTH(D), .AWD(AW)) u_bmem (
    .clk_i, .we_i(b_we_i), .waddr_i(b_addr_i), .wdata_i(b_data_i),
    .raddr_i(wr_addr), .rdata_o(b_word)
  );

  gfm_rf #(.DW(W), .DEPTH(D), .AWD(AW)) u_pmem (
    .clk_i, .we_i(p_we_i), .waddr_i(p_addr_i), .wdata_i(p_data_i),
    .raddr_i(wr_addr), .rdata_o(p_word)
  );

  assign c_raddr = busy_o ? rd_addr : c_addr_i;

  gfm_rf #(.DW(W), .DEPTH(D), .AWD(AW)) u_cmem (
    .clk_i, .we_i(wr_en), .waddr_i(wr_addr), .wdata_i(wr_data),
    .raddr_i(c_raddr), .rdata_o(c_rd)
  );

  gfm_pe #(.W(W), .D(D)) u_pe (
    .clk_i, .rst_ni, .en_i(busy_o), .cap_i(cap), .first_i(first), .tail_i(tail),
    .m_i(m_cur), .d_i(d_cur), .wr_idx_i(wr_addr), .a_bit_i(a_cur),
    .c_rd_i(c_rd), .b_word_i(b_word), .p_word_i(p_word), .wr_data_o(wr_data)
  );

  assign c_data_o = (!busy_o && int'(c_addr_i) < int'(d_cur)) ? c_rd : '0;
endmodule

// File: rtl/gfm_chk.sv
module gfm_chk #(
  parameter int W = 8,
  parameter int D = 4,
  localparam int MMAX = W * D,
  localparam int MW   = $clog2(MMAX + 1),
  localparam int AW   = (D > 1) ? $clog2(D) : 1,
  localparam int KW   = $clog2(D + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic [AW-1:0] c_addr_i,
  input logic [W-1:0]  c_data_o,
  input logic [MW-1:0] m_cur,
  input logic [KW-1:0] d_cur
);
  logic [W-1:0] top_mask;

  always_comb begin
    for (int b = 0; b < W; b++) top_mask[b] = ((int'(d_cur) - 1) * W + b < int'(m_cur));
  end

  a_r4_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r4_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r4_busy_fall_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r7_size_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(m_cur));

  a_r3_top_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && d_cur != '0 && int'(c_addr_i) == int'(d_cur) - 1) |-> ((c_data_o & ~top_mask) == '0));

  a_r5_beyond_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && int'(c_addr_i) >= int'(d_cur)) |-> (c_data_o == '0));
endmodule

bind gfmul_ws gfm_chk #(.W(W), .D(D)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .c_addr_i(c_addr_i), .c_data_o(c_data_o), .m_cur(m_cur), .d_cur(d_cur)
);

// File: tb/gfmul_ws_bench.sv
module gfmul_ws_bench;
  localparam int W = 8;
  localparam int D = 4;
  localparam int MMAX = W * D;
  localparam int MW = $clog2(MMAX + 1);
  localparam int AW = $clog2(D);
  localparam int BW = $clog2(MMAX);
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [MW-1:0] m_i = '0;
  logic a_we_i = 1'b0, a_bit_i = 1'b0;
  logic [BW-1:0] a_addr_i = '0;
  logic b_we_i = 1'b0, p_we_i = 1'b0;
  logic [AW-1:0] b_addr_i = '0, p_addr_i = '0, c_addr_i = '0;
  logic [W-1:0] b_data_i = '0, p_data_i = '0;
  logic [W-1:0] c_data_o;
  logic busy_o, done_o;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  gfmul_ws #(.W(W), .D(D)) u_gfmul_ws (
    .clk_i(clk), .rst_ni, .start_i, .m_i,
    .a_we_i, .a_addr_i, .a_bit_i,
    .b_we_i, .b_addr_i, .b_data_i,
    .p_we_i, .p_addr_i, .p_data_i,
    .c_addr_i, .c_data_o, .busy_o, .done_o
  );

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_mul(input int m, input logic [63:0] a, b, p);
    logic [63:0] c = '0, mk;
    logic msb;
    mk = (64'd1 << m) - 1;
    for (int i = m - 1; i >= 0; i--) begin
      msb = c[m-1];
      c = c << 1;
      if (msb) c = c ^ (p & mk);
      if (a[i]) c = c ^ (b & mk);
      c = c & mk;
    end
    return c;
  endfunction

  task automatic load(input int m, input logic [63:0] a, b, p);
    int d = (m + W - 1) / W;
    for (int i = 0; i < m; i++) begin
      a_we_i = 1'b1; a_addr_i = BW'(i); a_bit_i = a[i];
      tick;
    end
    a_we_i = 1'b0;
    for (int j = 0; j < d; j++) begin
      b_we_i = 1'b1; b_addr_i = AW'(j); b_data_i = b[j*W +: W];
      p_we_i = 1'b1; p_addr_i = AW'(j); p_data_i = p[j*W +: W];
      tick;
    end
    b_we_i = 1'b0; p_we_i = 1'b0;
  endtask

  task automatic read_check(input int m, input logic [63:0] exp, input string req);
    int d = (m + W - 1) / W;
    logic [W-1:0] e;
    for (int j = 0; j < D; j++) begin
      c_addr_i = AW'(j);
      #1;
      e = (j < d) ? exp[j*W +: W] : '0;
      check(c_data_o == e, req, c_data_o, e);
    end
  endtask

  // poke_at >= 0 raises start for one cycle that many cycles into the run
  task automatic run(input int m, input logic [63:0] a, b, p, input int poke_at, input string req);
    int d = (m + W - 1) / W;
    int n = m * (d + 1);
    logic [63:0] exp = ref_mul(m, a, b, p);
    load(m, a, b, p);
    m_i = MW'(m); start_i = 1'b1;
    tick;
    start_i = 1'b0;
    for (int cnt = 0; cnt < n; cnt++) begin
      check(busy_o && !done_o, "R4 busy window", {busy_o, done_o}, 2'b10);
      if (cnt == poke_at) begin start_i = 1'b1; m_i = MW'(1); end
      tick;
      start_i = 1'b0;
    end
    check(done_o && !busy_o, "R4 done pulse", {busy_o, done_o}, 2'b01);
    tick;
    check(!done_o && !busy_o, "R4 done one cycle", {busy_o, done_o}, 2'b00);
    read_check(m, exp, req);
  endtask

  initial begin
    logic [63:0] ra, rb, rp;
    int rm;
    repeat (3) tick;
    check(!busy_o && !done_o, "R1 reset flags", {busy_o, done_o}, 2'b00);
    c_addr_i = '0; #1;
    check(c_data_o == '0, "R1 reset read", c_data_o, 0);
    rst_ni = 1'b1;
    tick;
    check(!busy_o && !done_o, "R1 after release", {busy_o, done_o}, 2'b00);

    run(4, 64'hF, 64'hE, 64'h3, -1, "R9 known vector");
    run(1, 64'h1, 64'h1, 64'h1, -1, "R2 m=1 ones");
    run(1, 64'h1, 64'h0, 64'h1, -1, "R2 m=1 b zero");
    run(W, 64'hA5, 64'h3C, 64'h1B, -1, "R2 m=W");
    run(2 * W, 64'hBEEF, 64'h1234, 64'h002B, -1, "R2 m=2W");
    run(MMAX, 64'hDEADBEEF, 64'hCAFEF00D, 64'h0000008D, -1, "R2 m=max");
    run(13, 64'h0, 64'h1ABC, 64'h001B, -1, "R10 A zero");
    // larger product then smaller, same stores: accumulator and stale words must not leak
    run(MMAX, 64'hFFFFFFFF, 64'hFFFFFFFF, 64'hFFFFFFFF, -1, "R8 big run");
    run(11, 64'h7FF, 64'h7FF, 64'h005, -1, "R8 small after big");
    run(11, 64'h7FF, 64'h7FF, 64'h005, -1, "R3 R5 top word mask");
    run(19, 64'h5A5A5, 64'h3C3C3, 64'h00027, 7, "R7 start while busy");

    // R6: illegal sizes ignored, previous result stays readable
    m_i = '0; start_i = 1'b1; tick; start_i = 1'b0;
    repeat (3) begin
      check(!busy_o && !done_o, "R6 m=0 ignored", {busy_o, done_o}, 2'b00);
      tick;
    end
    m_i = MW'(MMAX + 1); start_i = 1'b1; tick; start_i = 1'b0;
    repeat (3) begin
      check(!busy_o && !done_o, "R6 m>max ignored", {busy_o, done_o}, 2'b00);
      tick;
    end
    read_check(19, ref_mul(19, 64'h5A5A5, 64'h3C3C3, 64'h00027), "R6 result kept");

    for (int t = 0; t < 24; t++) begin
      rm = 1 + ($urandom % MMAX);
      ra = {32'h0, $urandom}; rb = {32'h0, $urandom}; rp = {32'h0, $urandom} | 64'h1;
      if (t % 6 == 0) ra = '0;
      run(rm, ra, rb, rp, -1, (t % 6 == 0) ? "R10 random A zero" : "R2 random");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule